// File: doc/BRIEF.md
# DAC Clear-State and Fault Controller

This block decides which code reaches a DAC output stage and drives the shared fault pin. An active-low clear pin, passed through a synchronizer, can force the converter into a clear state. While it is in that state, the block sends out either a programmed clear code or a zero-state code in place of the normal DAC register code. How the block leaves the clear state depends on a remain-in-clear control bit. With that bit low, releasing the pin is enough. With it high, the pin must be released and then a DAC-register write, a load command, a low level on the load strobe, or a rewrite of the bit to 0 must follow.

The controller also registers the flags from the analog detectors for a shorted voltage output and an open current output. It combines these flags with the clear state to decide whether the open-drain fault pin pulls low. Control bits come from a register file elsewhere, and update events come from the command decoder as one-cycle pulses.

Top module: `dac_clear_fault_ctrl`

## Requirements
- R1: The block enters the clear state (`in_clear` = 1) on the third rising clock edge after `clr_pin_n` goes low, provided `clr_disable` = 0. While `clr_disable` = 1, the pin has no effect on `in_clear`, and update events have no effect while the pin is held low and enabled.
- R2: Outside the clear state, `out_code` equals `dac_code`.
- R3: In the clear state with `clr_use_reg` = 1, `out_code` equals `clr_code`.
- R4: In the clear state with `clr_use_reg` = 0, `out_code` is the zero-state code. This is 0x8000 (MSB only) when `volt_bipolar` = 1 and 0x0000 otherwise.
- R5: With `clr_hold` = 0, the clear state ends one clock after the synchronized pin reads high, or one clock after `clr_disable` goes to 1.
- R6: With `clr_hold` = 1, the clear state persists after the pin is released. It ends one clock after a `dac_wr` pulse, a `load_cmd` pulse, `ldac_n` low, or `clr_hold` going to 0.
- R7: Reset (`rst_n` low) forces `in_clear`, `flag_short` and `flag_open` to 0 and leaves the synchronizer reading "released".
- R8: `flag_short` and `flag_open` follow `short_det` and `open_det` one clock later, both when a condition is set and when it goes away.
- R9: `fault_oe` is 1 exactly when (`fault_en` = 1 and either flag is 1) or (`clr_flag_en` = 1 and `in_clear` = 1). `fault_n` is driven 0 while `fault_oe` = 1 and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| clr_pin_n | input | 1 | Asynchronous active-low clear pin |
| clr_disable | input | 1 | 1 ignores the clear pin |
| clr_use_reg | input | 1 | 1 selects clear code, 0 selects zero-state code while in clear |
| clr_hold | input | 1 | Remain-in-clear control bit |
| fault_en | input | 1 | Lets detector flags drive the fault pin |
| clr_flag_en | input | 1 | Lets the clear state drive the fault pin |
| volt_bipolar | input | 1 | Voltage output active in bipolar range |
| short_det | input | 1 | Voltage-output short detector |
| open_det | input | 1 | Current-output open detector |
| dac_wr | input | 1 | One-cycle DAC-register write pulse |
| load_cmd | input | 1 | One-cycle load-DAC command pulse |
| ldac_n | input | 1 | Active-low load strobe, synchronous |
| dac_code | input | CODE_W | DAC register contents |
| clr_code | input | CODE_W | Clear register contents |
| out_code | output | CODE_W | Code sent to the output stage |
| in_clear | output | 1 | Clear-state status |
| flag_short | output | 1 | Registered short flag |
| flag_open | output | 1 | Registered open flag |
| fault_oe | output | 1 | Fault pin pull-down enable |
| fault_n | output | 1 | Open-drain active-low fault pin |

## Verification
The assertions assume that every input except `clr_pin_n` is synchronous to `clk`. They also assume that `dac_wr` and `load_cmd` arrive as single-cycle pulses, so the exit checks can sample them on the edge they are meant for. The bench changes all inputs on the falling edge and pulses each update event for exactly one cycle. After each pin change, it waits for the full synchronizer delay before judging the clear state.

// File: rtl/dac_clear_fault_ctrl.sv
module dac_clear_fault_ctrl #(
  parameter int CODE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_pin_n,
  input  logic              clr_disable,
  input  logic              clr_use_reg,
  input  logic              clr_hold,
  input  logic              fault_en,
  input  logic              clr_flag_en,
  input  logic              volt_bipolar,
  input  logic              short_det,
  input  logic              open_det,
  input  logic              dac_wr,
  input  logic              load_cmd,
  input  logic              ldac_n,
  input  logic [CODE_W-1:0] dac_code,
  input  logic [CODE_W-1:0] clr_code,
  output logic [CODE_W-1:0] out_code,
  output logic              in_clear,
  output logic              flag_short,
  output logic              flag_open,
  output logic              fault_oe,
  output wire               fault_n
);

  localparam logic [CODE_W-1:0] ZERO_UNI = '0;
  localparam logic [CODE_W-1:0] ZERO_BIP = {1'b1, {(CODE_W-1){1'b0}}};

  logic [SYNC_STAGES-1:0] pin_sync;
  logic clr_req, upd_evt, clear_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sync <= '1;
    else        pin_sync <= {pin_sync[SYNC_STAGES-2:0], clr_pin_n};

  assign clr_req = ~pin_sync[SYNC_STAGES-1] & ~clr_disable;
  assign upd_evt = dac_wr | load_cmd | ~ldac_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              clear_q <= 1'b0;
    else if (clr_req)                        clear_q <= 1'b1;
    else if (clear_q && (!clr_hold || upd_evt)) clear_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_short <= 1'b0;
      flag_open  <= 1'b0;
    end else begin
      flag_short <= short_det;
      flag_open  <= open_det;
    end

  assign in_clear = clear_q;
  assign out_code = !clear_q    ? dac_code :
                    clr_use_reg ? clr_code :
                    volt_bipolar ? ZERO_BIP : ZERO_UNI;
  assign fault_oe = (fault_en & (flag_short | flag_open)) | (clr_flag_en & clear_q);
  assign fault_n  = fault_oe ? 1'b0 : 1'bz;

  // R1
  clr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> in_clear);
  // R6
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_clear && clr_hold && !upd_evt) |=> in_clear);
  // R6
  clr_upd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_clear && !clr_req && upd_evt) |=> !in_clear);
  // R5
  clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_clear && !clr_req && !clr_hold) |=> !in_clear);
  // R2
  pass_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_clear |-> out_code == dac_code);
  // R8
  short_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_det |=> flag_short);
  // R8
  open_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_det |=> !flag_open);
  // R9
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag_en && in_clear) |-> fault_oe);
  // R9
  quiet_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_en && !clr_flag_en) |-> !fault_oe);

endmodule

// File: tb/sim_dac_clear_fault_ctrl.sv
module sim_dac_clear_fault_ctrl;
  logic clk = 0, rst_n = 0;
  logic clr_pin_n = 1, clr_disable = 0, clr_use_reg = 0, clr_hold = 0;
  logic fault_en = 0, clr_flag_en = 0, volt_bipolar = 0;
  logic short_det = 0, open_det = 0, dac_wr = 0, load_cmd = 0, ldac_n = 1;
  logic [15:0] dac_code = 16'h1234, clr_code = 16'hABCD, out_code;
  logic in_clear, flag_short, flag_open, fault_oe;
  wire  fault_n;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  dac_clear_fault_ctrl u0 (.*);

  // stim {pin_n,dis,use_reg,bip,fen,flagen,short,open}, exp {clear,oe,code}
  localparam logic [25:0] VEC [10] = '{
    {8'h80, 2'b00, 16'h1234}, {8'h00, 2'b10, 16'h0000},
    {8'h14, 2'b11, 16'h8000}, {8'h34, 2'b11, 16'hABCD},
    {8'h64, 2'b00, 16'h1234}, {8'h8A, 2'b01, 16'h1234},
    {8'h89, 2'b01, 16'h1234}, {8'h83, 2'b00, 16'h1234},
    {8'h28, 2'b10, 16'hABCD}, {8'h84, 2'b00, 16'h1234}};

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s, input logic active);
    s = active; step(1); s = ~active;
  endtask

  task automatic enter_hold;
    clr_hold = 1; clr_pin_n = 0; step(4);
    chk("R1 enter", in_clear, 1);
    clr_pin_n = 1; step(5);
    chk("R6 stays after release", in_clear, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    step(2);
    chk("R7 reset clear", in_clear, 0);
    chk("R7 reset flags", {flag_short, flag_open}, 0);
    rst_n = 1; step(1);

    foreach (VEC[i]) begin
      {clr_pin_n, clr_disable, clr_use_reg, volt_bipolar,
       fault_en, clr_flag_en, short_det, open_det} = VEC[i][25:18];
      step(4);
      chk("R1/R5 clear state", in_clear, VEC[i][17]);
      chk("R9 fault_oe", fault_oe, VEC[i][16]);
      chk("R2/R3/R4 out_code", out_code, VEC[i][15:0]);
      chk("R8 flags", {flag_short, flag_open}, {short_det, open_det});
      if (fault_oe) chk("R9 pin low", fault_n, 0);
    end
    {clr_pin_n, clr_disable, clr_use_reg, volt_bipolar,
     fault_en, clr_flag_en, short_det, open_det} = 8'h80;
    step(2);

    // R1 synchronizer latency: third edge
    clr_pin_n = 0; step(2);
    chk("R1 not yet", in_clear, 0);
    step(1);
    chk("R1 third edge", in_clear, 1);
    // R5 exit via disable with pin still low
    clr_disable = 1; step(1);
    chk("R5 disable exit", in_clear, 0);
    step(3);
    chk("R1 disabled pin ignored", in_clear, 0);
    clr_disable = 0; clr_pin_n = 1; step(4);

    // R6 events while pin still low are ignored
    clr_hold = 1; clr_pin_n = 0; step(4);
    pulse(dac_wr, 1); step(1);
    chk("R1 update while held", in_clear, 1);
    clr_pin_n = 1; step(4);
    pulse(dac_wr, 1);
    chk("R6 dac_wr exit", in_clear, 0);

    enter_hold;
    pulse(load_cmd, 1);
    chk("R6 load exit", in_clear, 0);

    enter_hold;
    pulse(ldac_n, 0);
    chk("R6 ldac exit", in_clear, 0);

    enter_hold;
    clr_hold = 0; step(1);
    chk("R6 hold cleared exit", in_clear, 0);

    // R8 one-cycle follow
    short_det = 1; step(1);
    chk("R8 short set", flag_short, 1);
    short_det = 0; step(1);
    chk("R8 short cleared", flag_short, 0);

    // R7 reset during clear
    clr_hold = 1; clr_pin_n = 0; step(4);
    rst_n = 0; step(1);
    chk("R7 reset exits clear", in_clear, 0);
    clr_pin_n = 1; rst_n = 1; step(4);
    chk("R7 stays out", in_clear, 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule